// File: doc/BRIEF.md
# Dual-Source Enable and Power-Down Sequencer

This block governs the enables of three subsystems that share one clock: a transmitter, a receiver and a frequency oscillator. Each subsystem is switched on when its external enable pin or its bit in a software-written enable register is high. The effective enable is the OR of the two sources. Pins pass through a two-flop synchronizer before the OR. The OR result is registered, and all edge decisions are taken on that registered value.

When an effective enable rises, the subsystem leaves idle, raises its active output and emits a one-cycle start event. For the transmitter this event starts a transmit sequence. For the receiver it is an acquisition-mode restart. For the oscillator it sets a flag saying that new frequency data must be loaded. When an effective enable falls, the subsystem runs a reset sequence of fixed length, and its reset strobe is high throughout. The receiver sequence also clears the test-function select register. The enable register itself is never touched by a power-down.

A small write port reaches three locations: the enable register, the test-select register and a frequency-load command address. The datapaths themselves are not part of this block; only their control strobes are produced.

Top module: `ss_enable_seq`

## Requirements
- R1: The effective enable of each subsystem is the OR of its pin and its bit in the enable register at address 0x37, where bit 0 is the oscillator, bit 1 the transmitter and bit 2 the receiver. The active output rises at the second clock edge after the edge that writes the bit, or at the third clock edge after the first edge that samples a pin change.
- R2: A write to 0x37 stores wr_data[2:0] into cfg_enable and ignores the upper data bits. A write to 0x38 stores all eight bits into test_sel. A write to any other address changes neither register, and cfg_enable changes only on a write.
- R3: tx_start is a single-cycle pulse. It is high exactly in the first cycle in which tx_active is high after being low.
- R4: When the receiver's effective enable falls, rx_rst goes high one cycle after the registered enable drops, which is two edges after the clearing write. It stays high for exactly 6 cycles (RX_RST_CYCLES), and rx_active is low from the first of those cycles.
- R5: When the effective enable of the transmitter or the oscillator falls, tx_rst or osc_rst is high for exactly 1 cycle (TX_RST_CYCLES or OSC_RST_CYCLES), in the same cycle in which the active output drops.
- R6: A power-down leaves cfg_enable unchanged. The receiver power-down sets test_sel to 0 in the cycle in which rx_rst rises, and this clear wins over a simultaneous write to 0x38. Transmitter and oscillator power-downs leave test_sel unchanged.
- R7: rx_acq_restart pulses for one cycle on every receiver start, together with the rising edge of rx_active, whatever the receiver did before.
- R8: reload_req is set in the cycle in which osc_active rises. It is cleared at the next edge by a freq_load pulse or by a write of data 0x01 to address 0x00. A write of any other data to 0x00 leaves it set. A set and a clear in the same cycle resolve as set.
- R9: If an enable returns high while its reset sequence is running, the active output stays low until the sequence ends. The subsystem then starts one cycle after its reset strobe drops. An active output and its reset strobe are never high together.
- R10: After reset, every output is 0, including cfg_enable and test_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three subsystems |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_pin | input | 1 | Transmitter enable pin, asynchronous |
| rx_en_pin | input | 1 | Receiver enable pin, asynchronous |
| osc_en_pin | input | 1 | Oscillator enable pin, asynchronous |
| freq_load | input | 1 | Synchronous frequency-load strobe; clears reload_req |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tx_active | output | 1 | Transmitter running |
| tx_start | output | 1 | One-cycle transmit-sequence start |
| tx_rst | output | 1 | Transmitter datapath reset strobe |
| rx_active | output | 1 | Receiver running |
| rx_rst | output | 1 | Receiver datapath reset strobe |
| rx_acq_restart | output | 1 | One-cycle restart into acquisition mode |
| osc_active | output | 1 | Oscillator running |
| osc_rst | output | 1 | Oscillator reset strobe |
| reload_req | output | 1 | Frequency data must be reloaded |
| cfg_enable | output | 3 | Enable register contents |
| test_sel | output | DATA_W | Test-function select register |

## Verification
The bench goes after the receiver reset length. A sequencer that is off by one would show rx_rst for five or seven cycles. It also checks the clearing of test_sel, which a wrong design could miss or apply on a transmitter power-down as well. It re-enables a subsystem in the middle of its reset: a design that reacts to the raw level would raise rx_active while rx_rst is still high, and one that loses the request would never restart. The reload flag is probed with a write of the wrong data to address 0x00, which must not clear it, and with the freq_load pulse. Random pin and register traffic then checks the exclusion of active and reset outputs, the pulse shapes and the run lengths. Settled pin and register mixes check the OR of the two sources.

// File: rtl/enpd_pkg.sv
package enpd_pkg;

    localparam int SUB_N   = 3;
    localparam int SUB_OSC = 0;
    localparam int SUB_TX  = 1;
    localparam int SUB_RX  = 2;

    localparam int ADDR_FREQ   = 'h00;
    localparam int ADDR_ENABLE = 'h37;
    localparam int ADDR_TEST   = 'h38;
    localparam int FREQ_CMD    = 'h01;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_FLUSH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic start;
        logic flush;
    } seq_out_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int cnt_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/enpd_sync.sv
module enpd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/enpd_regs.sv
module enpd_regs
    import enpd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              test_clr,
    output logic [SUB_N-1:0]  en_bits,
    output logic [DATA_W-1:0] test_sel,
    output logic              freq_cmd
);
    logic hit_enable;
    logic hit_test;

    always_comb begin
        hit_enable = wr_en && (wr_addr == ADDR_W'(ADDR_ENABLE));
        hit_test   = wr_en && (wr_addr == ADDR_W'(ADDR_TEST));
        freq_cmd   = wr_en && (wr_addr == ADDR_W'(ADDR_FREQ))
                           && (wr_data == DATA_W'(FREQ_CMD));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_bits <= '0;
        end else if (hit_enable) begin
            en_bits <= wr_data[SUB_N-1:0];
        end
    end

    // receiver power-down clear takes priority over software
    always_ff @(posedge clk) begin
        if (rst) begin
            test_sel <= '0;
        end else if (test_clr) begin
            test_sel <= '0;
        end else if (hit_test) begin
            test_sel <= wr_data;
        end
    end
endmodule

// File: rtl/enpd_seq.sv
module enpd_seq
    import enpd_pkg::*;
#(
    parameter int RST_LEN = 6,
    parameter int CW      = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_eff,
    output logic     go_start,
    output logic     go_flush,
    output seq_out_t sq
);
    seq_state_e    st;
    logic [CW-1:0] cnt;
    logic          start_q;

    always_comb begin
        go_start = (st == SQ_IDLE) && en_eff;
        go_flush = (st == SQ_RUN) && !en_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cnt     <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= go_start;
            case (st)
                SQ_IDLE: begin
                    if (go_start) st <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (go_flush) begin
                        st  <= SQ_FLUSH;
                        cnt <= CW'(RST_LEN);
                    end
                end
                SQ_FLUSH: begin
                    if (cnt <= CW'(1)) begin
                        st  <= SQ_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        sq.active = (st == SQ_RUN);
        sq.flush  = (st == SQ_FLUSH);
        sq.start  = start_q;
    end
endmodule

// File: rtl/ss_enable_seq.sv
module ss_enable_seq
    import enpd_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 8,
    parameter int TX_RST_CYCLES  = 1,
    parameter int RX_RST_CYCLES  = 6,
    parameter int OSC_RST_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en_pin,
    input  logic              rx_en_pin,
    input  logic              osc_en_pin,
    input  logic              freq_load,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_active,
    output logic              tx_start,
    output logic              tx_rst,
    output logic              rx_active,
    output logic              rx_rst,
    output logic              rx_acq_restart,
    output logic              osc_active,
    output logic              osc_rst,
    output logic              reload_req,
    output logic [2:0]        cfg_enable,
    output logic [DATA_W-1:0] test_sel
);
    localparam int CW = cnt_bits(max3(TX_RST_CYCLES, RX_RST_CYCLES, OSC_RST_CYCLES));

    logic [SUB_N-1:0] pin_raw;
    logic [SUB_N-1:0] pin_s;
    logic [SUB_N-1:0] en_bits;
    logic [SUB_N-1:0] eff_q;
    logic [SUB_N-1:0] go_start;
    logic [SUB_N-1:0] go_flush;
    seq_out_t         sq [SUB_N];
    logic             freq_cmd;

    always_comb begin
        pin_raw          = '0;
        pin_raw[SUB_OSC] = osc_en_pin;
        pin_raw[SUB_TX]  = tx_en_pin;
        pin_raw[SUB_RX]  = rx_en_pin;
    end

    enpd_sync #(.W(SUB_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    enpd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .test_clr (go_flush[SUB_RX]),
        .en_bits  (en_bits),
        .test_sel (test_sel),
        .freq_cmd (freq_cmd)
    );

    // registered OR of the two enable sources
    always_ff @(posedge clk) begin
        if (rst) eff_q <= '0;
        else     eff_q <= pin_s | en_bits;
    end

    for (genvar i = 0; i < SUB_N; i++) begin : g_seq
        localparam int LEN = (i == SUB_RX) ? RX_RST_CYCLES :
                             (i == SUB_TX) ? TX_RST_CYCLES : OSC_RST_CYCLES;
        enpd_seq #(.RST_LEN(LEN), .CW(CW)) u_seq (
            .clk      (clk),
            .rst      (rst),
            .en_eff   (eff_q[i]),
            .go_start (go_start[i]),
            .go_flush (go_flush[i]),
            .sq       (sq[i])
        );
    end

    // a wake-up requesting new frequency data wins over a clear
    always_ff @(posedge clk) begin
        if (rst)                        reload_req <= 1'b0;
        else if (go_start[SUB_OSC])     reload_req <= 1'b1;
        else if (freq_load || freq_cmd) reload_req <= 1'b0;
    end

    always_comb begin
        tx_active      = sq[SUB_TX].active;
        tx_start       = sq[SUB_TX].start;
        tx_rst         = sq[SUB_TX].flush;
        rx_active      = sq[SUB_RX].active;
        rx_acq_restart = sq[SUB_RX].start;
        rx_rst         = sq[SUB_RX].flush;
        osc_active     = sq[SUB_OSC].active;
        osc_rst        = sq[SUB_OSC].flush;
        cfg_enable     = en_bits;
    end
endmodule

// File: rtl/ss_enable_seq_chk.sv
module ss_enable_seq_chk #(
    parameter int DATA_W         = 8,
    parameter int TX_RST_CYCLES  = 1,
    parameter int RX_RST_CYCLES  = 6,
    parameter int OSC_RST_CYCLES = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              tx_active,
    input logic              tx_start,
    input logic              tx_rst,
    input logic              rx_active,
    input logic              rx_rst,
    input logic              rx_acq_restart,
    input logic              osc_active,
    input logic              osc_rst,
    input logic              reload_req,
    input logic [2:0]        cfg_enable,
    input logic [DATA_W-1:0] test_sel
);
    logic [15:0] rx_run, tx_run, osc_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_run  <= '0;
            tx_run  <= '0;
            osc_run <= '0;
        end else begin
            rx_run  <= rx_rst  ? rx_run  + 16'd1 : 16'd0;
            tx_run  <= tx_rst  ? tx_run  + 16'd1 : 16'd0;
            osc_run <= osc_rst ? osc_run + 16'd1 : 16'd0;
        end
    end

    AST_RX_FLUSH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_rst) |-> (rx_run == 16'(RX_RST_CYCLES))); // R4
    AST_TX_FLUSH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_rst) |-> (tx_run == 16'(TX_RST_CYCLES))); // R5
    AST_OSC_FLUSH_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_rst) |-> (osc_run == 16'(OSC_RST_CYCLES))); // R5
    AST_TX_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_active && !$past(tx_active))); // R3
    AST_TX_START_ONE: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start); // R3
    AST_RX_ACQ_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> rx_acq_restart); // R7
    AST_TEST_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_rst) |-> (test_sel == '0)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_enable)); // R2
    AST_RELOAD_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_active) |-> reload_req); // R8
    AST_RX_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(rx_active && rx_rst)); // R9
    AST_TX_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(tx_active && tx_rst)); // R9
    AST_OSC_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(osc_active && osc_rst)); // R9
endmodule

bind ss_enable_seq ss_enable_seq_chk #(
    .DATA_W         (DATA_W),
    .TX_RST_CYCLES  (TX_RST_CYCLES),
    .RX_RST_CYCLES  (RX_RST_CYCLES),
    .OSC_RST_CYCLES (OSC_RST_CYCLES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .tx_active      (tx_active),
    .tx_start       (tx_start),
    .tx_rst         (tx_rst),
    .rx_active      (rx_active),
    .rx_rst         (rx_rst),
    .rx_acq_restart (rx_acq_restart),
    .osc_active     (osc_active),
    .osc_rst        (osc_rst),
    .reload_req     (reload_req),
    .cfg_enable     (cfg_enable),
    .test_sel       (test_sel)
);

// File: tb/sim_ss_enable_seq.sv
`timescale 1ns/1ps
module sim_ss_enable_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en_pin = 1'b0, rx_en_pin = 1'b0, osc_en_pin = 1'b0;
    logic       freq_load = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       tx_active, tx_start, tx_rst, rx_active, rx_rst, rx_acq_restart;
    logic       osc_active, osc_rst, reload_req;
    logic [2:0] cfg_enable;
    logic [7:0] test_sel;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ss_enable_seq u0 (
        .clk(clk), .rst(rst), .tx_en_pin(tx_en_pin), .rx_en_pin(rx_en_pin),
        .osc_en_pin(osc_en_pin), .freq_load(freq_load), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tx_active(tx_active),
        .tx_start(tx_start), .tx_rst(tx_rst), .rx_active(rx_active),
        .rx_rst(rx_rst), .rx_acq_restart(rx_acq_restart), .osc_active(osc_active),
        .osc_rst(osc_rst), .reload_req(reload_req), .cfg_enable(cfg_enable),
        .test_sel(test_sel)
    );

    function automatic logic [2:0] exp_active(input logic [2:0] pins, input logic [2:0] bits);
        return pins | bits;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int rxn;
        void'($urandom(32'd20240611));
        step(5);
        rst = 1'b0;
        step(1);
        // R10 reset state
        chk("R10", "outputs", {tx_active, tx_start, tx_rst, rx_active, rx_rst,
            rx_acq_restart, osc_active, osc_rst, reload_req}, 0);
        chk("R10", "cfg/test", {cfg_enable, test_sel}, 0);

        // R1 / R3 transmitter through register bit 1
        wr(8'h37, 8'h02);
        chk("R2", "cfg_enable", cfg_enable, 3'b010);
        step(1);
        chk("R1", "tx_active early", tx_active, 0);
        step(1);
        chk("R1", "tx_active", tx_active, 1);
        chk("R3", "tx_start", tx_start, 1);
        step(1);
        chk("R3", "tx_start one cycle", tx_start, 0);

        // R2 register decode
        wr(8'h38, 8'hA5);
        chk("R2", "test_sel", test_sel, 8'hA5);
        wr(8'h39, 8'hFF);
        chk("R2", "other addr", {cfg_enable, test_sel}, {3'b010, 8'hA5});
        wr(8'h37, 8'hFA);
        chk("R2", "upper bits ignored", cfg_enable, 3'b010);

        // R5 transmitter power-down
        wr(8'h37, 8'h00);
        step(1);
        chk("R5", "tx still active", tx_active, 1);
        step(1);
        chk("R5", "tx_rst on", {tx_active, tx_rst}, 2'b01);
        step(1);
        chk("R5", "tx_rst one cycle", tx_rst, 0);
        chk("R6", "tx pd keeps test_sel", test_sel, 8'hA5);

        // R1 / R7 receiver through pin
        rx_en_pin = 1'b1;
        step(3);
        chk("R1", "rx_active early", rx_active, 0);
        step(1);
        chk("R1", "rx_active pin", rx_active, 1);
        chk("R7", "acq restart", rx_acq_restart, 1);
        step(1);
        chk("R7", "acq one cycle", rx_acq_restart, 0);

        // R1 OR: register keeps rx on after pin drops
        wr(8'h37, 8'h04);
        rx_en_pin = 1'b0;
        step(6);
        chk("R1", "rx held by bit", rx_active, 1);

        // R4 / R6 receiver power-down
        wr(8'h37, 8'h00);
        step(1);
        chk("R4", "rx_rst not yet", {rx_active, rx_rst}, 2'b10);
        step(1);
        chk("R4", "rx_rst start", {rx_active, rx_rst}, 2'b01);
        chk("R6", "test_sel cleared", test_sel, 0);
        rxn = 1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (rx_rst) rxn++;
        end
        chk("R4", "rx_rst length", rxn, 6);
        chk("R6", "cfg kept", cfg_enable, 0);

        // R9 re-enable during receiver reset
        wr(8'h37, 8'h04);
        step(2);
        chk("R9", "rx up", rx_active, 1);
        wr(8'h37, 8'h00);
        step(2);
        chk("R9", "flush begun", rx_rst, 1);
        wr(8'h37, 8'h04);
        step(4);
        chk("R9", "held during flush", {rx_active, rx_rst}, 2'b01);
        step(1);
        chk("R9", "flush done", {rx_active, rx_rst}, 2'b00);
        step(1);
        chk("R9", "deferred start", {rx_active, rx_acq_restart}, 2'b11);
        wr(8'h37, 8'h00);
        step(10);

        // R8 oscillator reload flag
        wr(8'h38, 8'h3C);
        wr(8'h37, 8'h01);
        step(2);
        chk("R8", "osc up + reload", {osc_active, reload_req}, 2'b11);
        wr(8'h00, 8'h02);
        chk("R8", "wrong data keeps flag", reload_req, 1);
        wr(8'h00, 8'h01);
        chk("R8", "cmd clears flag", reload_req, 0);
        wr(8'h37, 8'h00);
        step(1);
        chk("R5", "osc still active", osc_active, 1);
        step(1);
        chk("R5", "osc_rst on", {osc_active, osc_rst}, 2'b01);
        step(1);
        chk("R5", "osc_rst one cycle", osc_rst, 0);
        chk("R6", "osc pd keeps regs", {cfg_enable, test_sel}, {3'b000, 8'h3C});
        osc_en_pin = 1'b1;
        step(4);
        chk("R8", "pin wake sets flag", {osc_active, reload_req}, 2'b11);
        freq_load = 1'b1;
        step(1);
        freq_load = 1'b0;
        chk("R8", "freq_load clears", reload_req, 0);
        osc_en_pin = 1'b0;
        step(10);

        // random traffic with invariant checks
        begin
            int rr = 0, rt = 0, ro = 0;
            logic ptx = tx_active;
            for (int it = 0; it < 3000; it++) begin
                logic [31:0] r;
                @(negedge clk);
                chk("R9", "rand overlap", {tx_active & tx_rst, rx_active & rx_rst,
                    osc_active & osc_rst}, 0);
                if (tx_start) chk("R3", "rand tx_start edge", {tx_active, ptx}, 2'b10);
                ptx = tx_active;
                if (rx_rst) rr++; else if (rr != 0) begin chk("R4", "rand rx len", rr, 6); rr = 0; end
                if (tx_rst) rt++; else if (rt != 0) begin chk("R5", "rand tx len", rt, 1); rt = 0; end
                if (osc_rst) ro++; else if (ro != 0) begin chk("R5", "rand osc len", ro, 1); ro = 0; end
                r = $urandom;
                if (r[3:0] == 0) tx_en_pin  = ~tx_en_pin;
                if (r[7:4] == 0) rx_en_pin  = ~rx_en_pin;
                if (r[11:8] == 0) osc_en_pin = ~osc_en_pin;
                freq_load = (r[15:12] == 0);
                wr_en = (r[18:16] == 0);
                case (r[20:19])
                    2'd0: wr_addr = 8'h37;
                    2'd1: wr_addr = 8'h38;
                    2'd2: wr_addr = 8'h00;
                    default: wr_addr = r[31:24];
                endcase
                wr_data = r[28:21];
            end
            @(negedge clk);
            wr_en = 1'b0; freq_load = 1'b0;
        end

        // settled mixes of pins and register bits
        for (int k = 0; k < 8; k++) begin
            logic [31:0] r;
            r = $urandom;
            {rx_en_pin, tx_en_pin, osc_en_pin} = r[2:0];
            wr(8'h37, {5'b0, r[5:3]});
            step(20);
            chk("R1", "settled OR", {rx_active, tx_active, osc_active},
                exp_active(r[2:0], r[5:3]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule